// File: doc/BRIEF.md
# Prioritised Memory Access Permission Checker

This block decides whether a single memory access may proceed. It takes an access request (start address, byte count, the permissions the access needs and whether the requester runs in machine mode) together with a table of protection entries. Each entry has an inclusive address range and a configuration byte. The block searches that table from the lowest index upward. The lowest active entry that the access touches settles the outcome.

The request is captured into a register when `req_valid` is high. The decision is formed combinationally from that captured request and the entry table. It is then registered onto the response outputs, so a response appears two clock edges after the request. The response gives allow/deny, whether an entry matched, the index of the matching entry, and the permission set that entry grants. The entry table is read directly from the inputs. It must stay stable while a request is in flight.

Configuration byte layout:
- Bit 0: read (R).
- Bit 1: write (W).
- Bit 2: execute (X).
- Bits 4:3: match mode; 00 means the entry is off.
- Bits 6:5: unused.
- Bit 7: lock.

Permission vectors on `req_perm` and `rsp_perm` use the same R/W/X bit positions.

Top module: `pmc_top`

## Requirements
- R1: A request accepted at a rising edge with `req_valid` high produces exactly one `rsp_valid` pulse two rising edges later.
- R2: Entries are searched from index 0 upward. The lowest-numbered active entry touched by the access gives `rsp_index`, and `rsp_hit` is 1, even when a higher entry would grant more.
- R3: An entry is touched when the first byte (`req_addr`) or the last byte lies inside its inclusive range. The last byte is `req_addr + req_size - 1`. A `req_size` of zero means the last byte is the final byte of the page holding `req_addr`, with a page of 2^PAGE_W bytes.
- R4: If exactly one of the first and last bytes lies inside the deciding entry, the access is denied and `rsp_perm` is 000.
- R5: An entry whose match mode field (bits 4:3) is 00 is never touched.
- R6: When the deciding entry is unlocked (bit 7 = 0), a machine-mode access is granted `rsp_perm` = 111.
- R7: When the deciding entry is locked, or the access is not in machine mode, `rsp_perm` equals the entry's R/W/X bits (bits 2:0).
- R8: `rsp_allow` is 1 exactly when no fully contained access is refused, that is, when every bit set in `req_perm` is also set in `rsp_perm`.
- R9: With no touched entry, `rsp_hit` is 0 and `rsp_index` is 0. A machine-mode access is then allowed with `rsp_perm` = 111. A lower-mode access is denied with 000 if any entry is active, and allowed with 111 if none is.
- R10: While `rsp_valid` is low, `rsp_allow`, `rsp_hit`, `rsp_index` and `rsp_perm` hold their last values.
- R11: During reset, `rsp_valid`, `rsp_allow`, `rsp_hit`, `rsp_index` and `rsp_perm` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | First byte address of the access |
| req_size | input | ADDR_W | Byte count; 0 means up to the end of the page |
| req_perm | input | 3 | Permissions needed: R bit 0, W bit 1, X bit 2 |
| req_mmode | input | 1 | 1 when the requester is in machine mode |
| ent_lo | input | N*ADDR_W | Inclusive low bound of each entry, entry i at slice i |
| ent_hi | input | N*ADDR_W | Inclusive high bound of each entry |
| ent_cfg | input | N*8 | Configuration byte of each entry |
| rsp_valid | output | 1 | Response strobe |
| rsp_allow | output | 1 | Access permitted |
| rsp_hit | output | 1 | An entry decided the access |
| rsp_index | output | IDX_W | Index of the deciding entry |
| rsp_perm | output | 3 | Permission set granted |

## Verification
A fixed table holds two overlapping entries with different rights, one entry that is switched off, and one locked entry. Requests against it show the following:
- An access in the overlap shows that the lower index wins and that a write is refused even though the wider entry would allow it.
- An access that crosses the end of entry 0 is refused as a partial match.
- An access inside the off entry falls through to the default policy.
- Machine-mode accesses to the unlocked and the locked entry show that the lock subjects machine mode to the entry's bits.
- Zero-size accesses near the start and near the end of a page show that the page end is used as the last byte.

A final pass with every entry off checks the permissive default for lower modes.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef struct packed {
    logic       lock;
    logic [1:0] rsv;
    logic [1:0] amode;
    logic       x;
    logic       w;
    logic       r;
  } pmc_cfg_t;

  localparam logic [1:0] AMODE_OFF = 2'b00;
  localparam logic [2:0] PERM_ALL  = 3'b111;
  localparam logic [2:0] PERM_NONE = 3'b000;

  function automatic logic [2:0] cfg_perm(input pmc_cfg_t c);
    return {c.x, c.w, c.r};
  endfunction
endpackage

// File: rtl/pmc_span.sv
module pmc_span #(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] size,
  output logic [ADDR_W-1:0] last
);
  localparam logic [ADDR_W-1:0] PAGE_MASK = {{(ADDR_W-PAGE_W){1'b0}}, {PAGE_W{1'b1}}};
  localparam logic [ADDR_W-1:0] ONE       = {{(ADDR_W-1){1'b0}}, 1'b1};

  always_comb begin
    if (size == '0) last = addr | PAGE_MASK;
    else            last = addr + size - ONE;
  end
endmodule

// File: rtl/pmc_entry_hit.sv
module pmc_entry_hit #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic              active,
  input  logic [ADDR_W-1:0] first,
  input  logic [ADDR_W-1:0] last,
  output logic              touch,
  output logic              partial
);
  logic in_first, in_last;
  always_comb begin
    in_first = active && (first >= lo) && (first <= hi);
    in_last  = active && (last  >= lo) && (last  <= hi);
    touch    = in_first | in_last;
    partial  = in_first ^ in_last;
  end
endmodule

// File: rtl/pmc_pick.sv
module pmc_pick #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     touch,
  input  logic [N-1:0]     partial,
  output logic             hit,
  output logic [IDX_W-1:0] idx,
  output logic             part
);
  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    part = 1'b0;
    for (int i = N-1; i >= 0; i--) begin
      if (touch[i]) begin
        hit  = 1'b1;
        idx  = IDX_W'(i);
        part = partial[i];
      end
    end
  end
endmodule

// File: rtl/pmc_top.sv
module pmc_top #(
  parameter int N      = 8,
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 12,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] req_size,
  input  logic [2:0]        req_perm,
  input  logic              req_mmode,
  input  logic [N*ADDR_W-1:0] ent_lo,
  input  logic [N*ADDR_W-1:0] ent_hi,
  input  logic [N*8-1:0]    ent_cfg,
  output logic              rsp_valid,
  output logic              rsp_allow,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_index,
  output logic [2:0]        rsp_perm
);
  import pmc_pkg::*;

  // stage 1: captured request
  logic              s1_valid;
  logic [ADDR_W-1:0] s1_addr, s1_size;
  logic [2:0]        s1_perm;
  logic              s1_mm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_addr  <= '0;
      s1_size  <= '0;
      s1_perm  <= '0;
      s1_mm    <= 1'b0;
    end else begin
      s1_valid <= req_valid;
      if (req_valid) begin
        s1_addr <= req_addr;
        s1_size <= req_size;
        s1_perm <= req_perm;
        s1_mm   <= req_mmode;
      end
    end
  end

  // decision logic
  logic [ADDR_W-1:0] last_byte;
  logic [N-1:0]      touch, partial, active;
  pmc_cfg_t          cfg [N];

  pmc_span #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_span (
    .addr(s1_addr), .size(s1_size), .last(last_byte)
  );

  for (genvar g = 0; g < N; g++) begin : g_ent
    assign cfg[g]    = pmc_cfg_t'(ent_cfg[g*8 +: 8]);
    assign active[g] = (cfg[g].amode != AMODE_OFF);
    pmc_entry_hit #(.ADDR_W(ADDR_W)) u_hit (
      .lo(ent_lo[g*ADDR_W +: ADDR_W]),
      .hi(ent_hi[g*ADDR_W +: ADDR_W]),
      .active(active[g]),
      .first(s1_addr),
      .last(last_byte),
      .touch(touch[g]),
      .partial(partial[g])
    );
  end

  logic             pk_hit, pk_part;
  logic [IDX_W-1:0] pk_idx;

  pmc_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
    .touch(touch), .partial(partial),
    .hit(pk_hit), .idx(pk_idx), .part(pk_part)
  );

  logic [2:0] nx_perm;
  logic       nx_allow;
  pmc_cfg_t   sel_cfg;

  always_comb begin
    sel_cfg = cfg[pk_idx];
    if (pk_hit) begin
      if (pk_part)                     nx_perm = PERM_NONE;
      else if (s1_mm && !sel_cfg.lock) nx_perm = PERM_ALL;
      else                             nx_perm = cfg_perm(sel_cfg);
    end else begin
      if (s1_mm || (active == '0))     nx_perm = PERM_ALL;
      else                             nx_perm = PERM_NONE;
    end
    nx_allow = ((s1_perm & ~nx_perm) == 3'b000) && !(pk_hit && pk_part);
  end

  // stage 2: registered response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_index <= '0;
      rsp_perm  <= '0;
    end else begin
      rsp_valid <= s1_valid;
      if (s1_valid) begin
        rsp_allow <= nx_allow;
        rsp_hit   <= pk_hit;
        rsp_index <= pk_idx;
        rsp_perm  <= nx_perm;
      end
    end
  end
endmodule

// File: rtl/pmc_top_chk.sv
module pmc_top_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [2:0]       req_perm,
  input logic             req_mmode,
  input logic             rsp_valid,
  input logic             rsp_allow,
  input logic             rsp_hit,
  input logic [IDX_W-1:0] rsp_index,
  input logic [2:0]       rsp_perm
);
  // R1
  resp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid, 2));

  // R8
  perm_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_allow) |-> (($past(req_perm, 2) & ~rsp_perm) == 3'b000));

  // R9
  mmode_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit && $past(req_mmode, 2)) |-> (rsp_allow && rsp_perm == 3'b111));

  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> ($stable(rsp_allow) && $stable(rsp_hit) && $stable(rsp_index) && $stable(rsp_perm)));

  // R9
  nohit_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_index == '0));
endmodule

bind pmc_top pmc_top_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_perm(req_perm),
  .req_mmode(req_mmode), .rsp_valid(rsp_valid), .rsp_allow(rsp_allow),
  .rsp_hit(rsp_hit), .rsp_index(rsp_index), .rsp_perm(rsp_perm)
);

// File: tb/pmc_top_test.sv
module pmc_top_test;
  localparam int N      = 8;
  localparam int ADDR_W = 32;
  localparam int PAGE_W = 12;
  localparam int IDX_W  = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic [ADDR_W-1:0] req_addr, req_size;
  logic [2:0]        req_perm;
  logic              req_mmode;
  logic [N*ADDR_W-1:0] ent_lo, ent_hi;
  logic [N*8-1:0]    ent_cfg;
  logic              rsp_valid, rsp_allow, rsp_hit;
  logic [IDX_W-1:0]  rsp_index;
  logic [2:0]        rsp_perm;

  always #5 clk = ~clk;

  pmc_top #(.N(N), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_perm(req_perm), .req_mmode(req_mmode),
    .ent_lo(ent_lo), .ent_hi(ent_hi), .ent_cfg(ent_cfg),
    .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_hit(rsp_hit),
    .rsp_index(rsp_index), .rsp_perm(rsp_perm)
  );

  typedef struct {
    int         due;
    logic       allow;
    logic       hit;
    int         idx;
    logic [2:0] perm;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   cycle  = 0;
  bit   done   = 0;

  always @(posedge clk) cycle <= cycle + 1;

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %s expected %s", tag, act, exp);
    end
  endtask

  task automatic set_ent(input int i, input logic [31:0] lo, input logic [31:0] hi, input logic [7:0] c);
    ent_lo[i*ADDR_W +: ADDR_W] = lo;
    ent_hi[i*ADDR_W +: ADDR_W] = hi;
    ent_cfg[i*8 +: 8] = c;
  endtask

  // driver: issue request and push expected result
  task automatic send(input logic [31:0] a, input logic [31:0] s, input logic [2:0] p,
                      input logic mm, input logic ea, input logic eh, input int ei,
                      input logic [2:0] ep, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = s; req_perm = p; req_mmode = mm;
    e.due = cycle + 2; e.allow = ea; e.hit = eh; e.idx = ei; e.perm = ep; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain;
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q.size() == 0) begin
        check(1'b0, "R1 unexpected response", "rsp_valid=1", "no response");
      end else begin
        exp_t e;
        e = q.pop_front();
        check(cycle == e.due, {e.tag, " R1 latency"},
              $sformatf("%0d", cycle), $sformatf("%0d", e.due));
        check(rsp_allow == e.allow && rsp_hit == e.hit && int'(rsp_index) == e.idx && rsp_perm == e.perm,
              e.tag,
              $sformatf("allow=%0b hit=%0b idx=%0d perm=%03b", rsp_allow, rsp_hit, rsp_index, rsp_perm),
              $sformatf("allow=%0b hit=%0b idx=%0d perm=%03b", e.allow, e.hit, e.idx, e.perm));
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0; req_perm = '0; req_mmode = 1'b0;
    ent_lo = '0; ent_hi = '0; ent_cfg = '0;
    set_ent(0, 32'h1000, 32'h10FF, 8'h09); // R only
    set_ent(1, 32'h1000, 32'h1FFF, 8'h0F); // RWX
    set_ent(2, 32'h2000, 32'h2FFF, 8'h07); // off
    set_ent(3, 32'h3000, 32'h3FFF, 8'h8D); // locked R|X
    repeat (3) @(negedge clk);
    // R11
    check(!rsp_valid && !rsp_allow && !rsp_hit && rsp_index == 0 && rsp_perm == 0, "R11 reset",
          $sformatf("%0b%0b%0b%0d%03b", rsp_valid, rsp_allow, rsp_hit, rsp_index, rsp_perm), "00000000");
    @(negedge clk); rst_n = 1'b1;

    send(32'h1010, 4, 3'b001, 0, 1, 1, 0, 3'b001, "R2 R7 user read e0");
    send(32'h1010, 4, 3'b010, 0, 0, 1, 0, 3'b001, "R2 R8 user write lowest wins");
    send(32'h10FC, 8, 3'b001, 0, 0, 1, 0, 3'b000, "R4 partial e0");
    send(32'h1200, 4, 3'b011, 0, 1, 1, 1, 3'b111, "R2 user rw e1");
    send(32'h2010, 4, 3'b001, 0, 0, 0, 0, 3'b000, "R5 R9 off entry user");
    send(32'h1010, 4, 3'b010, 1, 1, 1, 0, 3'b111, "R6 mmode unlocked");
    send(32'h3010, 4, 3'b010, 1, 0, 1, 3, 3'b101, "R7 mmode locked write");
    send(32'h3010, 4, 3'b100, 1, 1, 1, 3, 3'b101, "R7 mmode locked exec");
    send(32'h9000, 4, 3'b111, 1, 1, 0, 0, 3'b111, "R9 mmode nomatch");
    send(32'h10F0, 0, 3'b001, 0, 0, 1, 0, 3'b000, "R3 size0 page end partial");
    send(32'h1F00, 0, 3'b001, 0, 1, 1, 1, 3'b111, "R3 size0 inside e1");
    send(32'h0FFC, 8, 3'b001, 0, 0, 1, 0, 3'b000, "R3 R4 last byte only");
    drain();

    // R10: outputs hold while idle
    begin
      logic a0, h0; logic [IDX_W-1:0] i0; logic [2:0] p0;
      a0 = rsp_allow; h0 = rsp_hit; i0 = rsp_index; p0 = rsp_perm;
      repeat (3) @(negedge clk);
      check(rsp_allow == a0 && rsp_hit == h0 && rsp_index == i0 && rsp_perm == p0 && !rsp_valid,
            "R10 hold", $sformatf("%0b%0b%0d%03b", rsp_allow, rsp_hit, rsp_index, rsp_perm),
            $sformatf("%0b%0b%0d%03b", a0, h0, i0, p0));
    end

    for (int i = 0; i < N; i++) ent_cfg[i*8 +: 8] = 8'h07; // all off
    send(32'h1010, 4, 3'b111, 0, 1, 0, 0, 3'b111, "R9 R5 all off user");
    drain();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule